// File: doc/BRIEF.md
# Embedded-Sync YCbCr 4:2:2 Stream Decoder

This block takes a byte-wide 4:2:2 video stream, one byte per clock while the enable is high. Its line and field timing is carried inside the data itself as four-byte timing codes. The block finds each code and decodes its status byte into a field flag, a vertical-blanking flag and a start/end-of-active-video flag. It gives a one-clock pulse for each start code and each end code.

Between a start code and the next end code, the block sorts the active bytes into chroma-blue, luma, chroma-red and luma samples. It presents each completed group as a pixel pair with a one-clock valid strobe. Downstream logic uses the flags to track the raster and uses the pair strobe to take samples. It needs no separate sync pins.

Video bytes inside active lines are assumed to lie in the range 0x01 to 0xFE. The values 0x00 and 0xFF appear only in timing codes.

Top module: `ycc_sync_decoder`

## Requirements
- R1: While reset is asserted (`rst_n` low) and after it is released, before any timing code arrives, all outputs are 0.
- R2: A timing code is the bytes 0xFF, 0x00, 0x00 followed by a status byte. These are bytes accepted while `en` is high. A code is found wherever it starts. `sav_o` or `eav_o` is high for exactly one clock, in the cycle after the status byte is accepted, and the two are never high together.
- R3: Status bit 4 selects the kind of code: 1 is an end code (`eav_o`) and 0 is a start code (`sav_o`). `hflag_o` takes the value of bit 4.
- R4: `fld_o` takes status bit 6 (1 = second field, 0 = first field).
- R5: `vblank_o` takes status bit 5 (1 = vertical blanking).
- R6: Status bits 7 and 3..0 have no effect on any output.
- R7: `fld_o`, `vblank_o` and `hflag_o` change only in the cycle in which `sav_o` or `eav_o` is high, and hold their value between codes.
- R8: If the byte after 0xFF is not 0x00, or the byte after 0xFF 0x00 is not 0x00, the search restarts. If that byte is 0xFF, it counts as the first byte of a new code. No flag changes and no pulse fires.
- R9: After a start code, accepted bytes are taken in the repeating order Cb, Y0, Cr, Y1. In the cycle after Y1 is accepted, `pair_valid_o` is high for one clock, and `cb_o`, `y0_o`, `cr_o` and `y1_o` carry that group.
- R10: Every start code returns the byte order to Cb, even if the group before it was left incomplete.
- R11: `pair_valid_o` stays low from an end code until the next start code. Bytes that belong to a timing code are never taken as samples.
- R12: A byte presented while `en` is low is ignored: it neither advances code detection nor counts as a sample, and no pulse or strobe follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Byte qualifier: `din` is accepted when high |
| din | input | 8 | Multiplexed stream byte |
| fld_o | output | 1 | Field flag (second field = 1) |
| vblank_o | output | 1 | Vertical-blanking flag |
| hflag_o | output | 1 | Last code was an end code |
| sav_o | output | 1 | One-clock start-of-active-video pulse |
| eav_o | output | 1 | One-clock end-of-active-video pulse |
| cb_o | output | 8 | Cb sample of the last pair |
| y0_o | output | 8 | First luma sample of the last pair |
| cr_o | output | 8 | Cr sample of the last pair |
| y1_o | output | 8 | Second luma sample of the last pair |
| pair_valid_o | output | 1 | One-clock strobe for a completed pair |

## Verification
The interaction of interest is a start code that arrives while a pixel group is only partly collected. In that cycle the byte-order reset and the sample capture both want the phase counter. The bench provokes this by ending random lines with one to three extra bytes, and by sending two start codes in a row without an end code between them. Each result is judged by the next pair strobe: it must carry, as Cb, the first byte after the new status byte. The bench also places enable gaps inside timing codes and inside groups, so that stalled cycles meet both functions.

// File: rtl/ycc_pkg.sv
package ycc_pkg;

    // Progress through the three-byte preamble of a timing code
    typedef enum logic [1:0] {
        SRCH_FF   = 2'd0,
        SEEN_FF   = 2'd1,
        SEEN_00   = 2'd2,
        SEEN_0000 = 2'd3
    } pre_st_e;

    // Byte slots of one 4:2:2 group, in arrival order
    typedef enum logic [1:0] {
        PH_CB = 2'd0,
        PH_Y0 = 2'd1,
        PH_CR = 2'd2,
        PH_Y1 = 2'd3
    } phase_e;

endpackage

// File: rtl/ycc_trs_detect.sv
module ycc_trs_detect
    import ycc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [DATA_W-1:0] din,
    output logic              hunting,
    output logic              stat_hit,
    output logic              stat_is_end,
    output logic              f_q,
    output logic              v_q,
    output logic              h_q,
    output logic              sav_q,
    output logic              eav_q
);

    localparam logic [DATA_W-1:0] ALL_ONES  = {DATA_W{1'b1}};
    localparam logic [DATA_W-1:0] ALL_ZEROS = '0;
    localparam int F_BIT = DATA_W - 2;
    localparam int V_BIT = DATA_W - 3;
    localparam int H_BIT = DATA_W - 4;

    typedef struct packed {
        pre_st_e st;
        logic    f;
        logic    v;
        logic    h;
        logic    sav;
        logic    eav;
    } det_s;

    det_s r_q, r_d;

    always_comb begin
        r_d     = r_q;
        r_d.sav = 1'b0;
        r_d.eav = 1'b0;
        if (en) begin
            unique case (r_q.st)
                SRCH_FF: begin
                    r_d.st = (din == ALL_ONES) ? SEEN_FF : SRCH_FF;
                end
                SEEN_FF: begin
                    if (din == ALL_ZEROS)     r_d.st = SEEN_00;
                    else if (din == ALL_ONES) r_d.st = SEEN_FF;
                    else                      r_d.st = SRCH_FF;
                end
                SEEN_00: begin
                    if (din == ALL_ZEROS)     r_d.st = SEEN_0000;
                    else if (din == ALL_ONES) r_d.st = SEEN_FF;
                    else                      r_d.st = SRCH_FF;
                end
                SEEN_0000: begin
                    // status byte: only field, blanking and code-kind bits are used
                    r_d.f   = din[F_BIT];
                    r_d.v   = din[V_BIT];
                    r_d.h   = din[H_BIT];
                    r_d.sav = ~din[H_BIT];
                    r_d.eav = din[H_BIT];
                    r_d.st  = SRCH_FF;
                end
                default: r_d.st = SRCH_FF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: SRCH_FF, default: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign hunting     = (r_q.st == SRCH_FF);
    assign stat_hit    = en && (r_q.st == SEEN_0000);
    assign stat_is_end = din[H_BIT];
    assign f_q         = r_q.f;
    assign v_q         = r_q.v;
    assign h_q         = r_q.h;
    assign sav_q       = r_q.sav;
    assign eav_q       = r_q.eav;

    // R2: start and end pulses never coincide
    p_pulse_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(sav_q && eav_q));

    // R2: a pulse lasts a single clock (codes are at least four bytes apart)
    p_pulse_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sav_q || eav_q) |=> !(sav_q || eav_q));

    // R7: flags move only together with a code pulse
    p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sav_q && !eav_q) |-> ($stable(f_q) && $stable(v_q) && $stable(h_q)));

    // R12: a stalled byte cannot produce a pulse next cycle
    p_stall_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !(sav_q || eav_q));

endmodule

// File: rtl/ycc_pair_sorter.sv
module ycc_pair_sorter
    import ycc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [DATA_W-1:0] din,
    input  logic              hunting,
    input  logic              stat_hit,
    input  logic              stat_is_end,
    output logic [DATA_W-1:0] cb_q,
    output logic [DATA_W-1:0] y0_q,
    output logic [DATA_W-1:0] cr_q,
    output logic [DATA_W-1:0] y1_q,
    output logic              valid_q
);

    localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};

    typedef struct packed {
        logic              act;
        phase_e            ph;
        logic [DATA_W-1:0] cb_hold;
        logic [DATA_W-1:0] y0_hold;
        logic [DATA_W-1:0] cr_hold;
        logic [DATA_W-1:0] cb;
        logic [DATA_W-1:0] y0;
        logic [DATA_W-1:0] cr;
        logic [DATA_W-1:0] y1;
        logic              valid;
    } srt_s;

    srt_s s_q, s_d;
    logic take;

    // a byte is a sample only inside an active line and outside any code
    assign take = en && s_q.act && hunting && (din != ALL_ONES);

    always_comb begin
        s_d       = s_q;
        s_d.valid = 1'b0;
        if (stat_hit) begin
            s_d.act = ~stat_is_end;
            s_d.ph  = PH_CB;
        end else if (take) begin
            unique case (s_q.ph)
                PH_CB: begin
                    s_d.cb_hold = din;
                    s_d.ph      = PH_Y0;
                end
                PH_Y0: begin
                    s_d.y0_hold = din;
                    s_d.ph      = PH_CR;
                end
                PH_CR: begin
                    s_d.cr_hold = din;
                    s_d.ph      = PH_Y1;
                end
                PH_Y1: begin
                    s_d.cb    = s_q.cb_hold;
                    s_d.y0    = s_q.y0_hold;
                    s_d.cr    = s_q.cr_hold;
                    s_d.y1    = din;
                    s_d.valid = 1'b1;
                    s_d.ph    = PH_CB;
                end
                default: s_d.ph = PH_CB;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{ph: PH_CB, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign cb_q    = s_q.cb;
    assign y0_q    = s_q.y0;
    assign cr_q    = s_q.cr;
    assign y1_q    = s_q.y1;
    assign valid_q = s_q.valid;

    // R9: pair strobes are at least four accepted bytes apart
    p_valid_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q);

    // R11: bytes inside a code never complete a pair
    p_no_pair_in_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!hunting && !$past(hunting)) |-> !valid_q);

endmodule

// File: rtl/ycc_sync_decoder.sv
module ycc_sync_decoder
    import ycc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [DATA_W-1:0] din,
    output logic              fld_o,
    output logic              vblank_o,
    output logic              hflag_o,
    output logic              sav_o,
    output logic              eav_o,
    output logic [DATA_W-1:0] cb_o,
    output logic [DATA_W-1:0] y0_o,
    output logic [DATA_W-1:0] cr_o,
    output logic [DATA_W-1:0] y1_o,
    output logic              pair_valid_o
);

    logic hunting;
    logic stat_hit;
    logic stat_is_end;

    ycc_trs_detect #(.DATA_W(DATA_W)) u_detect (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .din         (din),
        .hunting     (hunting),
        .stat_hit    (stat_hit),
        .stat_is_end (stat_is_end),
        .f_q         (fld_o),
        .v_q         (vblank_o),
        .h_q         (hflag_o),
        .sav_q       (sav_o),
        .eav_q       (eav_o)
    );

    ycc_pair_sorter #(.DATA_W(DATA_W)) u_sorter (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .din         (din),
        .hunting     (hunting),
        .stat_hit    (stat_hit),
        .stat_is_end (stat_is_end),
        .cb_q        (cb_o),
        .y0_q        (y0_o),
        .cr_q        (cr_o),
        .y1_q        (y1_o),
        .valid_q     (pair_valid_o)
    );

    // R11: no pair strobe while the last code was an end code
    p_quiet_blank_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid_o |-> !hflag_o);

    // R2: strobe and code pulse come from bytes at least one apart
    p_pair_vs_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sav_o, eav_o, pair_valid_o}));

endmodule

// File: tb/tb_ycc_sync_decoder.sv
module tb_ycc_sync_decoder;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [7:0] din = 8'h00;

    logic       fld_o, vblank_o, hflag_o, sav_o, eav_o, pair_valid_o;
    logic [7:0] cb_o, y0_o, cr_o, y1_o;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ycc_sync_decoder #(.DATA_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .din(din),
        .fld_o(fld_o), .vblank_o(vblank_o), .hflag_o(hflag_o),
        .sav_o(sav_o), .eav_o(eav_o),
        .cb_o(cb_o), .y0_o(y0_o), .cr_o(cr_o), .y1_o(y1_o),
        .pair_valid_o(pair_valid_o)
    );

    // reference state derived from the requirements
    int         m_st  = 0;   // 0 search, 1 FF, 2 FF00, 3 FF0000
    logic       m_f = 0, m_v = 0, m_h = 0, m_act = 0;
    int         m_ph  = 0;
    logic [7:0] m_cb = 0, m_y0 = 0, m_cr = 0;
    logic       x_sav = 0, x_eav = 0, x_pv = 0;
    logic [7:0] x_cb = 0, x_y0 = 0, x_cr = 0, x_y1 = 0;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare();
        chk("R2 sav pulse", {7'd0, sav_o}, {7'd0, x_sav});
        chk("R3 eav pulse", {7'd0, eav_o}, {7'd0, x_eav});
        chk("R3/R7 hflag", {7'd0, hflag_o}, {7'd0, m_h});
        chk("R4/R7 field", {7'd0, fld_o}, {7'd0, m_f});
        chk("R5/R7 vblank", {7'd0, vblank_o}, {7'd0, m_v});
        chk("R9/R11 pair valid", {7'd0, pair_valid_o}, {7'd0, x_pv});
        if (x_pv) begin
            chk("R9/R10 cb", cb_o, x_cb);
            chk("R9 y0", y0_o, x_y0);
            chk("R9/R10 cr", cr_o, x_cr);
            chk("R9 y1", y1_o, x_y1);
        end
    endtask

    function automatic void model(input logic [7:0] b, input logic e);
        x_sav = 0; x_eav = 0; x_pv = 0;
        if (!e) return;                       // R12
        if (m_st == 3) begin
            m_f = b[6]; m_v = b[5]; m_h = b[4];  // R6: other bits unused
            x_sav = !b[4]; x_eav = b[4];
            m_act = !b[4]; m_ph = 0; m_st = 0;
            return;
        end
        if (m_act && m_st == 0 && b != 8'hFF) begin
            case (m_ph)
                0: m_cb = b;
                1: m_y0 = b;
                2: m_cr = b;
                default: begin
                    x_pv = 1; x_cb = m_cb; x_y0 = m_y0; x_cr = m_cr; x_y1 = b;
                end
            endcase
            m_ph = (m_ph + 1) % 4;
        end
        case (m_st)
            0: m_st = (b == 8'hFF) ? 1 : 0;
            default: m_st = (b == 8'h00) ? m_st + 1 : ((b == 8'hFF) ? 1 : 0);
        endcase
    endfunction

    task automatic put(input logic [7:0] b, input logic e);
        @(negedge clk);
        compare();
        en  = e;
        din = b;
        model(b, e);
    endtask

    function automatic logic [7:0] vid();
        return 8'($urandom_range(1, 254));
    endfunction

    task automatic code(input logic f, input logic v, input logic h);
        logic [7:0] s;
        s = 8'($urandom_range(0, 255));
        s[6] = f; s[5] = v; s[4] = h;
        put(8'hFF, 1); put(8'h00, 1); put(8'h00, 1); put(s, 1);
    endtask

    task automatic put_rand(input logic [7:0] b);
        if ($urandom_range(0, 7) == 0) put(vid(), 0);   // stalled cycle, R12
        put(b, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        compare();                            // R1 during reset
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare();                            // R1 after release

        // R6: ignored status bits set to opposite patterns
        put(8'hFF, 1); put(8'h00, 1); put(8'h00, 1); put(8'hCF, 1);
        put(8'hFF, 1); put(8'h00, 1); put(8'h00, 1); put(8'h30, 1);
        put(8'hFF, 1); put(8'h00, 1); put(8'h00, 1); put(8'h80, 1);

        // R8: broken preambles, then a restart on a second 0xFF
        put(8'hFF, 1); put(8'h55, 1); put(8'h12, 1);
        put(8'hFF, 1); put(8'h00, 1); put(8'h44, 1); put(8'h33, 1);
        put(8'hFF, 1); put(8'h00, 1); put(8'hFF, 1); put(8'h00, 1);
        put(8'h00, 1); put(8'h40, 1);

        // R12: stalls inside a code and inside a group
        put(8'hFF, 1); put(8'h00, 0); put(8'h00, 1); put(8'h77, 0);
        put(8'h00, 1); put(8'h60, 1);
        put(8'h11, 1); put(8'h22, 0); put(8'h22, 1); put(8'h33, 1);
        put(8'h44, 1);
        code(0, 0, 1);

        // R10: partial group, then two start codes in a row
        code(1, 0, 0);
        put(8'hA1, 1); put(8'hA2, 1);
        code(1, 0, 0);
        put(8'hB1, 1); put(8'hB2, 1); put(8'hB3, 1);
        code(1, 1, 0);
        put(8'hC1, 1); put(8'hC2, 1); put(8'hC3, 1); put(8'hC4, 1);
        code(1, 1, 1);
        // R11: bytes after an end code give no pairs
        for (int i = 0; i < 8; i++) put(vid(), 1);

        // random raster
        for (int ln = 0; ln < 60; ln++) begin
            logic f, v;
            int   nb;
            f = 1'($urandom_range(0, 1));
            v = 1'($urandom_range(0, 1));
            nb = $urandom_range(2, 20);
            for (int i = 0; i < nb; i++) begin
                case ($urandom_range(0, 9))
                    0: begin put(8'hFF, 1); put(vid(), 1); end          // R8
                    1: begin put(8'hFF, 1); put(8'h00, 1); put(vid(), 1); end
                    default: put_rand(vid());
                endcase
            end
            code(f, v, 0);
            nb = 4 * $urandom_range(1, 24) + (($urandom_range(0, 3) == 0) ? $urandom_range(1, 3) : 0);
            for (int i = 0; i < nb; i++) put_rand(vid());
            if ($urandom_range(0, 5) != 0) code(f, v, 1);
        end
        put(8'h10, 0);
        put(8'h10, 0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule